// File: doc/BRIEF.md
# Ring and Page Permission Gate

This block decides whether one memory access or privileged operation may go ahead. The caller supplies the code segment selector, the two translation entries found for the address (directory level and table level), the kind of access, the class of the instruction being executed, and the I/O privilege level. The block returns a registered verdict one clock later: a valid strobe, an allow flag and a two-bit cause code.

The selector's two low bits give the current ring, 0 to 3. For paging, the four rings collapse into two modes: rings 0 to 2 act as supervisor and ring 3 acts as user. Instruction gating still uses all four rings. Control-register, descriptor-table and invalidation operations are limited to ring 0. Port I/O and interrupt-flag operations are compared against the I/O privilege level.

Walking the page tables, caching translations, segment limit checks and raising exceptions are all done elsewhere.

Top module: `priv_access_checker`

## Requirements
- R1: While rst_ni is low, and until the first request after reset, valid_o, allow_o and cause_o are all 0.
- R2: A one-cycle req_i produces valid_o high on the next rising clock edge for exactly one cycle. allow_o and cause_o keep their values until the next request.
- R3: The current ring is cs_sel_i[1:0]. For memory access types 0 (fetch), 1 (read) and 2 (write), rings 0, 1 and 2 are supervisor mode and ring 3 is user mode.
- R4: An address is user-accessible only when bit 2 is 1 in both the directory entry and the table entry. A user-mode access to any other address gives cause 2'b01.
- R5: A supervisor-mode access is allowed whatever bit 2 of either entry holds.
- R6: Access type 3 (implicit system-structure access) is a supervisor-mode access at every ring, including ring 3.
- R7: If bit 0 (present) is 0 in either entry, the cause is 2'b11. This outranks every other cause.
- R8: Instruction class 1 (control-register move, descriptor-table load, page invalidation) is allowed only at ring 0. At rings 1 to 3 it gives cause 2'b10.
- R9: Instruction class 2 (port I/O, interrupt-flag clear) is allowed when the ring is numerically at or below iopl_i, and otherwise gives cause 2'b10. Classes 0 and 3 never give cause 2'b10.
- R10: When both a page protection violation and an instruction violation are present, the cause is 2'b01.
- R11: allow_o is 1 exactly when the reported cause is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request strobe |
| cs_sel_i | input | 16 | Code segment selector; bits 1:0 give the ring |
| dir_entry_i | input | 32 | Directory-level translation entry |
| tbl_entry_i | input | 32 | Table-level translation entry |
| acc_type_i | input | 2 | 0 fetch, 1 read, 2 write, 3 implicit system access |
| insn_class_i | input | 2 | 0 normal, 1 control/table/invalidate, 2 I/O or interrupt flag, 3 normal |
| iopl_i | input | 2 | I/O privilege level |
| valid_o | output | 1 | Verdict valid, one cycle after req_i |
| allow_o | output | 1 | Operation allowed |
| cause_o | output | 2 | 00 ok, 01 page protection, 10 privileged instruction, 11 not present |

## Verification
On every cycle, the assertions check the following:
- the strobe timing and the holding of the verdict between requests;
- that a missing present bit always yields cause 11;
- that control-class operations outside ring 0 are never allowed;
- that implicit accesses never produce a page protection fault;
- that a user access through a supervisor-only entry is flagged.

Only the bench scenarios can show the following:
- the complete cause ordering when several faults combine;
- the full ring-against-I/O-level comparison table;
- that rings 1 and 2 reach supervisor-only pages just as ring 0 does.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_READ     = 2'd1,
    ACC_WRITE    = 2'd2,
    ACC_IMPLICIT = 2'd3
  } acc_type_e;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_CTRL   = 2'd1,
    CLS_IO     = 2'd2,
    CLS_RSVD   = 2'd3
  } insn_class_e;

  typedef enum logic [1:0] {
    CAUSE_OK   = 2'b00,
    CAUSE_PROT = 2'b01,
    CAUSE_PRIV = 2'b10,
    CAUSE_NP   = 2'b11
  } cause_e;

  localparam int unsigned RING_W   = 2;
  localparam int unsigned USER_RING = 3;
endpackage

// File: rtl/ring_decode.sv
module ring_decode
  import priv_chk_pkg::*;
#(
  parameter int unsigned SEL_W = 16
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [1:0]        acc_type_i,
  output logic [RING_W-1:0] cpl_o,
  output logic              user_acc_o
);
  logic unused_sel_hi;
  assign unused_sel_hi = ^sel_i[SEL_W-1:RING_W];

  assign cpl_o = sel_i[RING_W-1:0];
  // implicit system-structure accesses always run as supervisor
  assign user_acc_o = (cpl_o == RING_W'(USER_RING)) &&
                      (acc_type_i != ACC_IMPLICIT);
endmodule

// File: rtl/page_rights.sv
module page_rights #(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned P_BIT  = 0,
  parameter int unsigned US_BIT = 2
) (
  input  logic [LEVELS-1:0][PTE_W-1:0] entries_i,
  output logic                         all_present_o,
  output logic                         user_ok_o
);
  logic [LEVELS-1:0] present_v;
  logic [LEVELS-1:0] user_v;
  logic [LEVELS-1:0] unused_bits;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic [PTE_W-1:0] masked;
    assign present_v[g] = entries_i[g][P_BIT];
    assign user_v[g]    = entries_i[g][US_BIT];
    always_comb begin
      masked         = entries_i[g];
      masked[P_BIT]  = 1'b0;
      masked[US_BIT] = 1'b0;
    end
    assign unused_bits[g] = ^masked;
  end

  logic unused_rest;
  assign unused_rest   = ^unused_bits;
  assign all_present_o = &present_v;
  // a single supervisor-only level anywhere on the path closes the page to user mode
  assign user_ok_o     = &user_v;
endmodule

// File: rtl/insn_gate.sv
module insn_gate
  import priv_chk_pkg::*;
(
  input  logic [RING_W-1:0] cpl_i,
  input  logic [RING_W-1:0] iopl_i,
  input  logic [1:0]        cls_i,
  output logic              priv_ok_o
);
  always_comb begin
    unique case (cls_i)
      CLS_CTRL: priv_ok_o = (cpl_i == '0);
      CLS_IO:   priv_ok_o = (cpl_i <= iopl_i);
      default:  priv_ok_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/priv_access_checker.sv
module priv_access_checker
  import priv_chk_pkg::*;
#(
  parameter int unsigned SEL_W = 16,
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [SEL_W-1:0] cs_sel_i,
  input  logic [PTE_W-1:0] dir_entry_i,
  input  logic [PTE_W-1:0] tbl_entry_i,
  input  logic [1:0]       acc_type_i,
  input  logic [1:0]       insn_class_i,
  input  logic [1:0]       iopl_i,
  output logic             valid_o,
  output logic             allow_o,
  output logic [1:0]       cause_o
);
  localparam int unsigned LEVELS = 2;

  logic [RING_W-1:0]             cpl;
  logic                          user_acc, all_present, user_ok, priv_ok;
  logic [LEVELS-1:0][PTE_W-1:0]  entries;
  cause_e                        cause_d;

  assign entries = {dir_entry_i, tbl_entry_i};

  ring_decode #(.SEL_W(SEL_W)) u_ring (
    .sel_i      (cs_sel_i),
    .acc_type_i (acc_type_i),
    .cpl_o      (cpl),
    .user_acc_o (user_acc)
  );

  page_rights #(.LEVELS(LEVELS), .PTE_W(PTE_W), .P_BIT(0), .US_BIT(2)) u_rights (
    .entries_i     (entries),
    .all_present_o (all_present),
    .user_ok_o     (user_ok)
  );

  insn_gate u_gate (
    .cpl_i     (cpl),
    .iopl_i    (iopl_i),
    .cls_i     (insn_class_i),
    .priv_ok_o (priv_ok)
  );

  // priority: not present, then page protection, then instruction privilege
  always_comb begin
    if (!all_present)              cause_d = CAUSE_NP;
    else if (user_acc && !user_ok) cause_d = CAUSE_PROT;
    else if (!priv_ok)             cause_d = CAUSE_PRIV;
    else                           cause_d = CAUSE_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      allow_o <= 1'b0;
      cause_o <= CAUSE_OK;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        allow_o <= (cause_d == CAUSE_OK);
        cause_o <= cause_d;
      end
    end
  end

  a_r2_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  a_r2_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(cause_o) && $stable(allow_o)));
  a_r7_not_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(dir_entry_i[0] && tbl_entry_i[0])) |=> (cause_o == 2'b11 && !allow_o));
  a_r8_ctrl_ring0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && insn_class_i == 2'd1 && cs_sel_i[1:0] != 2'd0) |=> !allow_o);
  a_r6_implicit_no_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_type_i == 2'd3) |=> (cause_o != 2'b01));
  a_r4_user_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cs_sel_i[1:0] == 2'd3 && acc_type_i != 2'd3 &&
     dir_entry_i[0] && tbl_entry_i[0] && !(dir_entry_i[2] && tbl_entry_i[2]))
    |=> (cause_o == 2'b01));
  a_r11_allow_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (allow_o == (cause_o == 2'b00)));
endmodule

// File: tb/priv_access_checker_bench.sv
`timescale 1ns/1ps
module priv_access_checker_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] cs_sel_i = '0;
  logic [31:0] dir_entry_i = '0;
  logic [31:0] tbl_entry_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic [1:0]  insn_class_i = '0;
  logic [1:0]  iopl_i = '0;
  logic        valid_o, allow_o;
  logic [1:0]  cause_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  priv_access_checker u_priv_access_checker (.*);

  localparam logic [31:0] E_USER = 32'h0000_1007; // present, user
  localparam logic [31:0] E_SUP  = 32'h0000_1003; // present, supervisor-only
  localparam logic [31:0] E_NP   = 32'h0000_1006; // not present

  function automatic logic [1:0] model(input logic [1:0] ring, input logic [31:0] d,
                                       input logic [31:0] t, input logic [1:0] acc,
                                       input logic [1:0] cls, input logic [1:0] io);
    if (!(d[0] && t[0])) return 2'b11;
    if (ring == 2'd3 && acc != 2'd3 && !(d[2] && t[2])) return 2'b01;
    if (cls == 2'd1 && ring != 2'd0) return 2'b10;
    if (cls == 2'd2 && ring > io) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [15:0] sel, input logic [31:0] d,
                     input logic [31:0] t, input logic [1:0] acc,
                     input logic [1:0] cls, input logic [1:0] io);
    logic [1:0] e;
    e = model(sel[1:0], d, t, acc, cls, io);
    @(negedge clk_i);
    cs_sel_i = sel; dir_entry_i = d; tbl_entry_i = t;
    acc_type_i = acc; insn_class_i = cls; iopl_i = io; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check(req, {valid_o, allow_o, cause_o}, {1'b1, e == 2'b00, e});
  endtask

  task automatic t_reset;
    check("R1 reset", {valid_o, allow_o, cause_o}, 4'b0000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", {valid_o, allow_o, cause_o}, 4'b0000);
  endtask

  task automatic t_strobe_hold;
    run("R2 strobe", 16'h0013, E_USER, E_SUP, 2'd1, 2'd0, 2'd0);
    // change inputs with no request: outputs must hold, valid must drop
    cs_sel_i = 16'h0000; dir_entry_i = E_NP;
    @(negedge clk_i);
    check("R2 hold", {valid_o, allow_o, cause_o}, {1'b0, 1'b0, 2'b01});
  endtask

  task automatic t_user_pages;
    run("R4 user/user", 16'h0023, E_USER, E_USER, 2'd1, 2'd0, 2'd0);
    run("R4 dir sup", 16'h0023, E_SUP, E_USER, 2'd2, 2'd0, 2'd0);
    run("R4 tbl sup fetch", 16'h0023, E_USER, E_SUP, 2'd0, 2'd0, 2'd0);
    run("R3 upper sel bits", 16'hFFF3, E_SUP, E_SUP, 2'd1, 2'd0, 2'd0);
  endtask

  task automatic t_super_pages;
    for (int r = 0; r < 3; r++)
      run("R5 R3 supervisor rings", 16'(16'h0010 | r), E_SUP, E_SUP, 2'd2, 2'd0, 2'd0);
  endtask

  task automatic t_implicit;
    run("R6 implicit ring3", 16'h0003, E_SUP, E_SUP, 2'd3, 2'd0, 2'd0);
    run("R6 implicit ring3 ctrl", 16'h0003, E_SUP, E_USER, 2'd3, 2'd1, 2'd0);
  endtask

  task automatic t_not_present;
    run("R7 dir np", 16'h0000, E_NP, E_USER, 2'd1, 2'd0, 2'd0);
    run("R7 tbl np over prot", 16'h0003, E_SUP, E_NP, 2'd1, 2'd1, 2'd0);
  endtask

  task automatic t_ctrl;
    for (int r = 0; r < 4; r++)
      run("R8 ctrl class", 16'(r), E_USER, E_USER, 2'd0, 2'd1, 2'd3);
  endtask

  task automatic t_io;
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 4; l++)
        run("R9 io vs iopl", 16'(r), E_USER, E_USER, 2'd1, 2'd2, 2'(l));
    run("R9 class3 normal", 16'h0003, E_USER, E_USER, 2'd1, 2'd3, 2'd0);
  endtask

  task automatic t_priority;
    run("R10 prot over priv", 16'h0003, E_SUP, E_USER, 2'd1, 2'd1, 2'd0);
    run("R11 allow with ok", 16'h0000, E_SUP, E_SUP, 2'd2, 2'd1, 2'd0);
  endtask

  initial begin
    t_reset();
    t_strobe_hold();
    t_user_pages();
    t_super_pages();
    t_implicit();
    t_not_present();
    t_ctrl();
    t_io();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule